// File: doc/BRIEF.md
# Golden-Signature Upset Test Sequencer

This block drives a device under test (DUT) through a repeating stimulus cycle of a fixed number of steps. It compares the DUT output word at every step against an expected word held in a small signature memory, and it logs soft upsets. Before a run, software or a test host loads one reference word per step through a write port. A start pulse clears both error counters. The sequencer then holds the DUT unclocked for a hold interval and runs one verification pass over the whole cycle.

A mismatch during a verification pass is a synchronization error, not an upset. It puts the DUT into a timed reset and then retries verification. A clean verification pass leads to continuous checking. In that phase a mismatch is an upset. The block captures the step index, the observed word and the expected word in an error record. The record is held on a valid/ready output, and DUT clocking stalls until the record is accepted. The block then resets the DUT for the recovery interval and verifies again before monitoring resumes. A stop request returns the sequencer to idle from any state.

Both intervals are given in milliseconds and are counted in system clocks from a clocks-per-millisecond parameter. A simulation can therefore use short values.

Top module: `sig_upset_seq`

## Requirements
- R1: While reset is applied, and after reset until the first start, dut_rst is 1, dut_ce is 0, rec_valid is 0 and both counters read 0.
- R2: A start pulse in idle holds the DUT for exactly HOLD_MS*CLK_PER_MS clocks with dut_rst=0 and dut_ce=0. dut_ce rises in the next clock.
- R3: A mismatch at step k of a verification pass ends that pass after k+1 clocks of dut_ce. sync_cnt rises by one, upset_cnt is unchanged and no record is raised. dut_rst is then high for RST_MS*CLK_PER_MS clocks before a new pass starts at step 0.
- R4: After STEPS consecutive matching verification steps, dut_ce stays 1 continuously and rec_valid stays 0 for as long as every step matches.
- R5: A mismatch during continuous checking raises rec_valid with rec_step equal to the DUT step index (0 to STEPS-1), rec_obs equal to the DUT word and rec_exp equal to the stored signature word. upset_cnt rises by one on the same edge.
- R6: While rec_valid=1 and rec_ready=0, the record fields stay unchanged, dut_ce is 0 and the counters do not move.
- R7: A record is accepted on a clock with rec_valid=1 and rec_ready=1. From the next clock, dut_rst is 1 for exactly RST_MS*CLK_PER_MS clocks, and then dut_ce=1 starts a verification pass.
- R8: Both counters are CNT_W bits wide, never decrease except on start, and saturate at 2**CNT_W-1.
- R9: A start accepted from idle clears both counters to 0 on that edge.
- R10: A stop sampled in any state forces dut_rst=1, dut_ce=0 and rec_valid=0 from the next clock. The block then stays idle until a start.
- R11: A word written with sig_we=1 to address sig_waddr becomes the reference for that step from the following clock, including during continuous checking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run from idle; clears the counters |
| stop | input | 1 | Return to idle from any state |
| sig_we | input | 1 | Signature memory write enable |
| sig_waddr | input | SW | Signature step address, SW = clog2(STEPS) |
| sig_wdata | input | DW | Expected DUT word for that step |
| dut_rst | output | 1 | Reset to the DUT |
| dut_ce | output | 1 | Clock enable to the DUT; one step per enabled clock |
| dut_q | input | DW | DUT output word for the current step |
| rec_valid | output | 1 | Error record pending |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_step | output | SW | Step index of the upset |
| rec_obs | output | DW | Observed DUT word |
| rec_exp | output | DW | Expected signature word |
| upset_cnt | output | CNT_W | Saturating upset count |
| sync_cnt | output | CNT_W | Saturating synchronization-error count |

## Verification
dut_rst and dut_ce are decoded from the registered state. They change one clock after the start, stop, timer expiry or mismatch that causes the change. The record fields and both counters load on the same edge that samples the mismatching step. The bench drives inputs and samples outputs on falling edges only. It measures the hold and recovery intervals, and the dut_ce clocks of a failed verification pass, by counting falling-edge samples against the exact lengths in the requirements. A DUT model in the bench advances one step per enabled clock and returns to step 0 on dut_rst. The bench can therefore predict the step index and both words of each record without looking inside the design.

// File: rtl/sig_upset_pkg.sv
package sig_upset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HOLD    = 3'd1,
    ST_VERIFY  = 3'd2,
    ST_RUN     = 3'd3,
    ST_REPORT  = 3'd4,
    ST_RECOVER = 3'd5
  } seq_state_e;

endpackage

// File: rtl/sig_mem.sv
module sig_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          dec,
  output logic          done
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr) begin
      q_d = '0;
    end else if (inc && !(&q)) begin
      q_d = q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/sig_upset_seq.sv
module sig_upset_seq
  import sig_upset_pkg::*;
#(
  parameter int STEPS      = 8,
  parameter int DW         = 8,
  parameter int CLK_PER_MS = 4,
  parameter int HOLD_MS    = 10,
  parameter int RST_MS     = 10,
  parameter int CNT_W      = 8,
  localparam int SW        = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             sig_we,
  input  logic [SW-1:0]    sig_waddr,
  input  logic [DW-1:0]    sig_wdata,
  output logic             dut_rst,
  output logic             dut_ce,
  input  logic [DW-1:0]    dut_q,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [SW-1:0]    rec_step,
  output logic [DW-1:0]    rec_obs,
  output logic [DW-1:0]    rec_exp,
  output logic [CNT_W-1:0] upset_cnt,
  output logic [CNT_W-1:0] sync_cnt
);

  localparam int HOLD_CLK = HOLD_MS * CLK_PER_MS;
  localparam int RST_CLK  = RST_MS * CLK_PER_MS;
  localparam int IVL_MAX  = (HOLD_CLK > RST_CLK) ? HOLD_CLK : RST_CLK;
  localparam int TW       = $clog2(IVL_MAX + 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign srst_n = rsync_q[1];

  seq_state_e    state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic [DW-1:0] exp_word;
  logic          mism, last_step;
  logic          tmr_load, tmr_dec, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          cap_en, up_inc, sy_inc, cnt_clr;

  sig_mem #(.DEPTH(STEPS), .DW(DW)) u_sig (
    .clk   (clk),
    .we    (sig_we),
    .waddr (sig_waddr),
    .wdata (sig_wdata),
    .raddr (step_q),
    .rdata (exp_word)
  );

  ivl_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .done     (tmr_done)
  );

  sat_cnt #(.W(CNT_W)) u_upset (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (cnt_clr),
    .inc   (up_inc),
    .q     (upset_cnt)
  );

  sat_cnt #(.W(CNT_W)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (cnt_clr),
    .inc   (sy_inc),
    .q     (sync_cnt)
  );

  assign mism      = (dut_q != exp_word);
  assign last_step = (step_q == SW'(STEPS - 1));

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    cap_en   = 1'b0;
    up_inc   = 1'b0;
    sy_inc   = 1'b0;
    cnt_clr  = 1'b0;
    if (stop) begin
      state_d = ST_IDLE;
      step_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_d  = ST_HOLD;
            cnt_clr  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TW'(HOLD_CLK - 1);
          end
        end
        ST_HOLD, ST_RECOVER: begin
          if (tmr_done) begin
            state_d = ST_VERIFY;
            step_d  = '0;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        ST_VERIFY: begin
          if (mism) begin
            sy_inc   = 1'b1;
            state_d  = ST_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CLK - 1);
          end else if (last_step) begin
            state_d = ST_RUN;
            step_d  = '0;
          end else begin
            step_d = step_q + SW'(1);
          end
        end
        ST_RUN: begin
          if (mism) begin
            up_inc  = 1'b1;
            cap_en  = 1'b1;
            state_d = ST_REPORT;
          end else begin
            step_d = last_step ? '0 : step_q + SW'(1);
          end
        end
        ST_REPORT: begin
          if (rec_ready) begin
            state_d  = ST_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CLK - 1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rec_step <= '0;
      rec_obs  <= '0;
      rec_exp  <= '0;
    end else if (cap_en) begin
      rec_step <= step_q;
      rec_obs  <= dut_q;
      rec_exp  <= exp_word;
    end
  end

  assign dut_rst   = (state_q == ST_IDLE) || (state_q == ST_RECOVER);
  assign dut_ce    = (state_q == ST_VERIFY) || (state_q == ST_RUN);
  assign rec_valid = (state_q == ST_REPORT);

endmodule

// File: rtl/sig_upset_seq_chk.sv
module sig_upset_seq_chk #(
  parameter int DW    = 8,
  parameter int SW    = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             dut_rst,
  input logic             dut_ce,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [SW-1:0]    rec_step,
  input logic [DW-1:0]    rec_obs,
  input logic [DW-1:0]    rec_exp,
  input logic [CNT_W-1:0] upset_cnt,
  input logic [CNT_W-1:0] sync_cnt
);

  // R1: the DUT is never clocked while held in reset
  a_r1_rst_ce_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dut_rst && dut_ce));

  // R6: a pending record does not change
  a_r6_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready && !stop |=>
      rec_valid && $stable(rec_step) && $stable(rec_obs) && $stable(rec_exp));

  // R6: DUT clocking stalls while a record is pending
  a_r6_stall_ce: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !dut_ce);

  // R5: a new record comes with an upset count step
  a_r5_rec_counts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> (upset_cnt != $past(upset_cnt)) || (&upset_cnt));

  // R7: acceptance leads into DUT reset
  a_r7_accept_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready && !stop |=> dut_rst && !rec_valid);

  // R8: counters only move up unless a start clears them
  a_r8_upset_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> upset_cnt >= $past(upset_cnt));

  a_r8_sync_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> sync_cnt >= $past(sync_cnt));

  // R10: stop returns to idle
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> dut_rst && !dut_ce && !rec_valid);

endmodule

bind sig_upset_seq sig_upset_seq_chk #(.DW(DW), .SW(SW), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stop      (stop),
  .dut_rst   (dut_rst),
  .dut_ce    (dut_ce),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_step  (rec_step),
  .rec_obs   (rec_obs),
  .rec_exp   (rec_exp),
  .upset_cnt (upset_cnt),
  .sync_cnt  (sync_cnt)
);

// File: tb/sig_upset_seq_tb_top.sv
module sig_upset_seq_tb_top;

  localparam int STEPS    = 8;
  localparam int DW       = 8;
  localparam int SW       = 3;
  localparam int CNT_W    = 8;
  localparam int HOLD_CLK = 40;
  localparam int RST_CLK  = 40;
  localparam int WD       = 150000;

  // vector table: kind (0 = DUT word flipped, 1 = signature rewritten), step, mask
  localparam int NV = 5;
  localparam bit        VK [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit [2:0]  VS [NV] = '{3'd3, 3'd7, 3'd5, 3'd0, 3'd6};
  localparam bit [7:0]  VM [NV] = '{8'h01, 8'h80, 8'h10, 8'hFF, 8'h55};

  logic clk, rst_n, start, stop, sig_we, rec_ready;
  logic [SW-1:0]    sig_waddr, rec_step;
  logic [DW-1:0]    sig_wdata, dut_q, rec_obs, rec_exp;
  logic             dut_rst, dut_ce, rec_valid;
  logic [CNT_W-1:0] upset_cnt, sync_cnt;

  int checks = 0;
  int errors = 0;

  // DUT model
  logic [SW-1:0] mctr;
  logic          fault_en;
  logic [SW-1:0] fault_step;
  logic [DW-1:0] fault_mask;

  function automatic logic [7:0] pat_of(int i);
    return 8'(32'h3C + i * 32'h17);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mctr <= '0;
    else if (dut_rst) mctr <= '0;
    else if (dut_ce) mctr <= (mctr == SW'(STEPS - 1)) ? '0 : mctr + SW'(1);
  end

  assign dut_q = pat_of(int'(mctr)) ^ ((fault_en && (mctr == fault_step)) ? fault_mask : 8'h00);

  sig_upset_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .sig_we(sig_we), .sig_waddr(sig_waddr), .sig_wdata(sig_wdata),
    .dut_rst(dut_rst), .dut_ce(dut_ce), .dut_q(dut_q),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_step(rec_step),
    .rec_obs(rec_obs), .rec_exp(rec_exp),
    .upset_cnt(upset_cnt), .sync_cnt(sync_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic write_sig(int a, logic [7:0] d);
    @(negedge clk);
    sig_we = 1'b1; sig_waddr = SW'(a); sig_wdata = d;
    @(negedge clk);
    sig_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_run(string req);
    int run_len = 0;
    int guard = 0;
    while (run_len <= STEPS && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (dut_ce && !rec_valid) run_len++;
      else run_len = 0;
    end
    chk(req, "reached continuous checking", 32'(guard < 2000), 32'd1);
  endtask

  task automatic wait_valid(string req);
    int guard = 0;
    while (!rec_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk(req, "record raised", 32'(rec_valid), 32'd1);
  endtask

  // count falling-edge samples with dut_rst high, starting at the current one
  task automatic count_rst(output int n);
    n = 0;
    while (dut_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int exp_up;
    logic [7:0] e_obs, e_exp;
    logic [2:0] s_step;
    logic [CNT_W-1:0] s_up;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; sig_we = 1'b0; rec_ready = 1'b0;
    sig_waddr = '0; sig_wdata = '0;
    fault_en = 1'b0; fault_step = '0; fault_mask = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "dut_rst in reset", 32'(dut_rst), 32'd1);
    chk("R1", "dut_ce in reset", 32'(dut_ce), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "rec_valid after reset", 32'(rec_valid), 32'd0);
    chk("R1", "counters after reset", 32'({upset_cnt, sync_cnt}), 32'd0);
    chk("R1", "dut_rst idle", 32'(dut_rst), 32'd1);

    for (int i = 0; i < STEPS; i++) write_sig(i, pat_of(i));

    // R2: hold interval
    pulse_start();
    n = 0;
    while (!dut_ce && n < 1000) begin
      if (!dut_rst) n++;
      @(negedge clk);
    end
    chk("R2", "hold clocks", 32'(n), 32'(HOLD_CLK));

    // R4: clean run
    wait_run("R4");
    n = 0;
    for (int c = 0; c < 30; c++) begin
      if (dut_ce && !rec_valid) n++;
      @(negedge clk);
    end
    chk("R4", "continuous clocks without record", 32'(n), 32'd30);

    // vector table: R5, R6, R7, R11
    exp_up = 0;
    for (int v = 0; v < NV; v++) begin
      wait_run("R7");
      e_obs = VK[v] ? pat_of(int'(VS[v])) : (pat_of(int'(VS[v])) ^ VM[v]);
      e_exp = VK[v] ? (pat_of(int'(VS[v])) ^ VM[v]) : pat_of(int'(VS[v]));
      if (VK[v]) write_sig(int'(VS[v]), pat_of(int'(VS[v])) ^ VM[v]);
      else begin
        fault_step = VS[v]; fault_mask = VM[v]; fault_en = 1'b1;
      end
      wait_valid("R5");
      exp_up++;
      chk(VK[v] ? "R11" : "R5", "rec_step", 32'(rec_step), 32'(VS[v]));
      chk(VK[v] ? "R11" : "R5", "rec_obs", 32'(rec_obs), 32'(e_obs));
      chk(VK[v] ? "R11" : "R5", "rec_exp", 32'(rec_exp), 32'(e_exp));
      chk("R5", "upset_cnt", 32'(upset_cnt), 32'(exp_up));
      s_step = rec_step; s_up = upset_cnt;
      repeat (3) @(negedge clk);
      chk("R6", "record held", 32'({rec_valid, rec_step}), 32'({1'b1, s_step}));
      chk("R6", "stalled dut_ce", 32'(dut_ce), 32'd0);
      chk("R6", "count stable", 32'(upset_cnt), 32'(s_up));
      fault_en = 1'b0;
      if (VK[v]) write_sig(int'(VS[v]), pat_of(int'(VS[v])));
      rec_ready = 1'b1;
      @(negedge clk);
      rec_ready = 1'b0;
      chk("R7", "record cleared", 32'(rec_valid), 32'd0);
      count_rst(n);
      chk("R7", "recovery reset clocks", 32'(n), 32'(RST_CLK));
      chk("R7", "verify after recovery", 32'(dut_ce), 32'd1);
    end

    // R10: stop while a record is pending
    wait_run("R10");
    fault_step = 3'd4; fault_mask = 8'h0F; fault_en = 1'b1;
    wait_valid("R10");
    pulse_stop();
    chk("R10", "idle after stop", 32'({dut_rst, dut_ce, rec_valid}), 32'(3'b100));
    fault_en = 1'b0;
    n = 0;
    for (int c = 0; c < 10; c++) begin
      if (dut_ce || rec_valid) n++;
      @(negedge clk);
    end
    chk("R10", "stays idle", 32'(n), 32'd0);

    // R9 and R3: counters clear on start, then a verification mismatch
    fault_step = 3'd2; fault_mask = 8'h20; fault_en = 1'b1;
    pulse_start();
    chk("R9", "counters cleared", 32'({upset_cnt, sync_cnt}), 32'd0);
    n = 0;
    while (!dut_ce && n < 1000) begin
      n++;
      @(negedge clk);
    end
    n = 0;
    while (dut_ce && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R3", "verify clocks before sync error", 32'(n), 32'd3);
    chk("R3", "sync_cnt", 32'(sync_cnt), 32'd1);
    chk("R3", "upset_cnt unchanged", 32'(upset_cnt), 32'd0);
    chk("R3", "no record", 32'(rec_valid), 32'd0);
    fault_en = 1'b0;
    count_rst(n);
    chk("R3", "sync reset clocks", 32'(n), 32'(RST_CLK));
    wait_run("R4");
    chk("R4", "sync_cnt after clean pass", 32'(sync_cnt), 32'd1);

    // R8: saturation of the sync counter
    pulse_stop();
    fault_step = 3'd0; fault_mask = 8'h01; fault_en = 1'b1;
    pulse_start();
    repeat (300 * (RST_CLK + 1) + HOLD_CLK + 10) @(negedge clk);
    chk("R8", "sync_cnt saturated", 32'(sync_cnt), 32'd255);
    chk("R8", "upset_cnt untouched", 32'(upset_cnt), 32'd0);

    // R9 clear from saturation, R10 stop during hold
    pulse_stop();
    fault_en = 1'b0;
    pulse_start();
    chk("R9", "saturated counter cleared", 32'(sync_cnt), 32'd0);
    repeat (5) @(negedge clk);
    pulse_stop();
    n = 0;
    for (int c = 0; c < 60; c++) begin
      if (dut_ce || !dut_rst) n++;
      @(negedge clk);
    end
    chk("R10", "stop during hold stays idle", 32'(n), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule